// File: doc/BRIEF.md
# Converter enable and power-good sequencer

This block controls three downstream power converters and their shared power-good signal. Each converter has an enable pin that is held low to keep the converter off and left floating to let it soft-start. The block drives these pins through pull-down controls. It releases all three converters together, and only when two conditions hold at once: an external asynchronous "on" input is high, and an "on" bit that bus software writes is set. The external input passes through a synchronizer before the block uses it.

Two 5-bit divider-code registers, A and B, come in from the bus side. A select input picks which of them drives the divider code output. When the code on that output changes, whether because the selected register was written or because the select input moved between registers that hold different values, power-good is pulled low for a fixed window. The same window starts when the converters are released. A new trigger during a window restarts the window. Power-good is also pulled low whenever the converters are held off. The window length is a parameter in clock cycles, and a second parameter clamps it to a hard maximum.

Top module: `conv_enable_seq`

## Requirements
- R1: While reset is asserted, `en_pd_o` is all ones, `pg_pd_o` is 1 and `code_o` is 5'b11111.
- R2: The converters are released only when the synchronized `ext_on_i` and `bus_on_i` are both high. A rise of `ext_on_i` reaches `en_pd_o` after three clock edges: two synchronizer stages and the enable register. `bus_on_i` reaches `en_pd_o` after one edge.
- R3: Encoding of `en_pd_o`: a bit value of 1 pulls the enable low and holds the converter off, and 0 releases it (high impedance). All `N_CONV` bits always carry the same value.
- R4: With `sel_i` = 0, `code_o` follows `code_a_i`. With `sel_i` = 1, it follows `code_b_i`. Each change appears one clock edge after it is presented.
- R5: When `code_o` takes a new value, `pg_pd_o` is 1 for exactly the effective window, counted in clock cycles from the cycle in which the new code first appears. Rewriting the same value causes no window.
- R6: When the converters are released, `pg_pd_o` stays 1 for exactly the effective window, counted from the cycle in which `en_pd_o` drops to 0.
- R7: A trigger during an active window reloads the full window, so the window ends one full window after the last trigger.
- R8: The effective window is the smaller of `WIN_CYCLES` and `WIN_MAX_CYCLES`. The timer count never exceeds it.
- R9: While `en_pd_o` is 1, `pg_pd_o` is 1, whatever the divider code does.
- R10: Toggling `sel_i` starts a window only if the two registers hold different codes.
- R11: Changing the register that is not selected leaves `code_o` unchanged and starts no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_on_i | input | 1 | External asynchronous on request |
| bus_on_i | input | 1 | Bus-programmed on bit (cleared by its register on reset) |
| sel_i | input | 1 | Register select: 0 picks A, 1 picks B |
| code_a_i | input | 5 | Divider code register A |
| code_b_i | input | 5 | Divider code register B |
| code_o | output | 5 | Selected divider code |
| en_pd_o | output | N_CONV | Enable pull-down controls, 1 pulls low |
| pg_pd_o | output | 1 | Power-good pull-down control, 1 pulls low |

## Verification
The bench builds two instances that share the same stimulus. One uses a 6-cycle window under an 8-cycle cap, and the other asks for 12 cycles under the same cap, so it exercises the clamp. The short windows allow the bench to sweep all 32 values of register A, to walk pairs of A and B (some equal, some not) through select toggles, and to visit every combination of the two on inputs. In each case the bench measures the exact pulse lengths on both instances, so it can compare the requested window with the clamped one.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;

  // Effective window: requested length clamped to the hard maximum.
  function automatic int eff_window(input int req, input int cap);
    return (req < cap) ? req : cap;
  endfunction

  // Counter width able to hold 0..n.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic code_t pick_code(input logic sel, input code_t a, input code_t b);
    return sel ? b : a;
  endfunction
endpackage

// File: rtl/cseq_sync.sv
module cseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  generate
    for (genvar s = 0; s < N; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[N-1];
endmodule

// File: rtl/cseq_code_sel.sv
module cseq_code_sel
  import cseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_i,
  input  code_t code_a_i,
  input  code_t code_b_i,
  output code_t code_o,
  output logic  chg_o
);
  code_t code_q;
  code_t code_nxt;

  assign code_nxt = pick_code(sel_i, code_a_i, code_b_i);
  assign chg_o    = (code_nxt != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '1;
    else        code_q <= code_nxt;
  end

  assign code_o = code_q;

  AST_CODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> code_o == pick_code($past(sel_i), $past(code_a_i), $past(code_b_i))) else $error("code"); // R4
endmodule

// File: rtl/cseq_pg_timer.sv
module cseq_pg_timer
  import cseq_pkg::*;
#(
  parameter int WIN_CYCLES     = 50,
  parameter int WIN_MAX_CYCLES = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic busy_o
);
  localparam int WIN_EFF = eff_window(WIN_CYCLES, WIN_MAX_CYCLES);
  localparam int CW      = cnt_width(WIN_EFF);
  localparam logic [CW-1:0] WIN_LD = CW'(WIN_EFF);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (trig_i)        cnt <= WIN_LD;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= WIN_LD) else $error("window bound"); // R8
  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> busy_o && cnt == WIN_LD) else $error("restart"); // R7
  AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !trig_i) |=> cnt == $past(cnt) - 1'b1) else $error("countdown"); // R5
endmodule

// File: rtl/conv_enable_seq.sv
module conv_enable_seq
  import cseq_pkg::*;
#(
  parameter int N_CONV         = 3,
  parameter int WIN_CYCLES     = 50,
  parameter int WIN_MAX_CYCLES = 70,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_on_i,
  input  logic              bus_on_i,
  input  logic              sel_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N_CONV-1:0] en_pd_o,
  output logic              pg_pd_o
);
  logic ext_on_s;
  logic run_req;
  logic run_q;
  logic release_ev;
  logic code_chg_ev;
  logic win_trig;
  logic win_busy;

  cseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_on_i),
    .q_o   (ext_on_s)
  );

  assign run_req = ext_on_s & bus_on_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_req;
  end

  assign release_ev = run_req & ~run_q;

  cseq_code_sel u_code (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .code_a_i (code_a_i),
    .code_b_i (code_b_i),
    .code_o   (code_o),
    .chg_o    (code_chg_ev)
  );

  assign win_trig = release_ev | code_chg_ev;

  cseq_pg_timer #(
    .WIN_CYCLES     (WIN_CYCLES),
    .WIN_MAX_CYCLES (WIN_MAX_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (win_trig),
    .busy_o (win_busy)
  );

  generate
    for (genvar g = 0; g < N_CONV; g++) begin : g_en
      assign en_pd_o[g] = ~run_q;
    end
  endgenerate

  assign pg_pd_o = ~run_q | win_busy;

  AST_EN_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(en_pd_o) == 0) || ($countones(en_pd_o) == N_CONV)) else $error("uniform"); // R3
  AST_EN_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pd_o[0] |-> $past(bus_on_i)) else $error("needs bit"); // R2
  AST_OFF_PG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_pd_o[0] |-> pg_pd_o) else $error("off pg"); // R9
  AST_RELEASE_PG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_pd_o[0]) |-> pg_pd_o) else $error("release pg"); // R6
  AST_CODE_CHANGE_PG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> pg_pd_o) else $error("code pg"); // R5
endmodule

// File: tb/conv_enable_seq_test.sv
module conv_enable_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int W_A = 6;
  localparam int W_B = 12;
  localparam int W_CAP = 8;
  localparam int EXP_A = (W_A < W_CAP) ? W_A : W_CAP;
  localparam int EXP_B = (W_B < W_CAP) ? W_B : W_CAP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_on = 1'b0, bus_on = 1'b0, sel = 1'b0;
  logic [4:0] code_a = 5'd31, code_b = 5'd31;
  logic [4:0] code_o, code_o2;
  logic [2:0] en_pd, en_pd2;
  logic pg_pd, pg_pd2;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_enable_seq #(.N_CONV(3), .WIN_CYCLES(W_A), .WIN_MAX_CYCLES(W_CAP), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .ext_on_i(ext_on), .bus_on_i(bus_on), .sel_i(sel),
    .code_a_i(code_a), .code_b_i(code_b), .code_o(code_o), .en_pd_o(en_pd), .pg_pd_o(pg_pd));

  conv_enable_seq #(.N_CONV(3), .WIN_CYCLES(W_B), .WIN_MAX_CYCLES(W_CAP), .SYNC_STAGES(2)) uut_clamp (
    .clk(clk), .rst_n(rst_n), .ext_on_i(ext_on), .bus_on_i(bus_on), .sel_i(sel),
    .code_a_i(code_a), .code_b_i(code_b), .code_o(code_o2), .en_pd_o(en_pd2), .pg_pd_o(pg_pd2));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; counts consecutive cycles of pg pull-down on both instances.
  task automatic measure(output int l1, output int l2);
    bit d1 = 0, d2 = 0;
    l1 = 0; l2 = 0;
    for (int k = 0; k < 40; k++) begin
      if (!d1) begin if (pg_pd) l1++; else d1 = 1; end
      if (!d2) begin if (pg_pd2) l2++; else d2 = 1; end
      if (d1 && d2) break;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int l1, l2;
    logic [4:0] prev, bv;
    repeat (3) @(negedge clk);
    check("R1 en", en_pd, 7);
    check("R1 pg", pg_pd, 1);
    check("R1 code", code_o, 31);
    rst_n = 1'b1;
    @(negedge clk);
    bus_on = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 ext off", en_pd, 7);
    ext_on = 1'b1;
    @(negedge clk);
    check("R2 sync1", en_pd, 7);
    @(negedge clk);
    check("R2 sync2", en_pd, 7);
    @(negedge clk);
    check("R2 release", en_pd, 0);
    check("R3 clamp inst", en_pd2, 0);
    check("R6 pg at release", pg_pd, 1);
    measure(l1, l2);
    check("R6 window", l1, EXP_A);
    check("R8 clamped window", l2, EXP_B);

    // R5: sweep all codes on register A
    prev = 5'd31;
    for (int v = 0; v < 32; v++) begin
      code_a = v[4:0];
      @(negedge clk);
      check("R5 code", code_o, v);
      measure(l1, l2);
      check("R5 window", l1, (v[4:0] != prev) ? EXP_A : 0);
      check("R8 window", l2, (v[4:0] != prev) ? EXP_B : 0);
      prev = v[4:0];
    end
    code_a = prev;
    @(negedge clk);
    measure(l1, l2);
    check("R5 same value", l1, 0);

    // R4 / R10: select toggles
    for (int i = 0; i < 16; i++) begin
      bv = (i % 4 == 0) ? i[4:0] : 5'(31 - i);
      sel = 1'b0; code_a = i[4:0]; code_b = bv;
      @(negedge clk);
      measure(l1, l2);
      sel = 1'b1;
      @(negedge clk);
      check("R4 sel B", code_o, bv);
      measure(l1, l2);
      check("R10 toggle", l1, (bv != i[4:0]) ? EXP_A : 0);
      sel = 1'b0;
      @(negedge clk);
      check("R4 sel A", code_o, i);
      measure(l1, l2);
    end

    // R11: unselected register change
    sel = 1'b1; code_b = 5'd17;
    @(negedge clk);
    measure(l1, l2);
    code_a = 5'd2;
    @(negedge clk);
    check("R11 code", code_o, 17);
    measure(l1, l2);
    check("R11 no window", l1, 0);
    check("R11 no window clamp", l2, 0);

    // R7: retrigger
    sel = 1'b0; code_a = 5'd5; code_b = 5'd20;
    @(negedge clk);
    measure(l1, l2);
    code_a = 5'd9;
    @(negedge clk);
    check("R7 first", pg_pd, 1);
    @(negedge clk);
    @(negedge clk);
    check("R7 still low", pg_pd, 1);
    code_a = 5'd12;
    @(negedge clk);
    measure(l1, l2);
    check("R7 restart", l1, EXP_A);
    check("R7 restart clamp", l2, EXP_B);

    // R9: off holds power-good low
    bus_on = 1'b0;
    @(negedge clk);
    check("R9 off en", en_pd, 7);
    l1 = 0;
    for (int k = 0; k < 20; k++) begin
      if (k == 5) code_a = 5'd3;
      if (!pg_pd) l1++;
      @(negedge clk);
    end
    check("R9 pg low while off", l1, 0);

    // R2: all on-input combinations
    for (int c = 0; c < 4; c++) begin
      ext_on = c[0]; bus_on = c[1];
      repeat (6) @(negedge clk);
      check("R2 combo", en_pd, (c == 3) ? 0 : 7);
    end
    repeat (20) @(negedge clk);
    check("R6 pg settles", pg_pd, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule